// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block connects N sources to N destinations through a blocking multistage fabric of 2x2 switch elements. Every source offers a request made of a valid flag, a destination port number and a data word. The request is steered through log2(N) stages. Before each stage the lines are rewired by a perfect shuffle, and each element routes on one bit of the destination number. After the last stage the request arrives on the output port whose index equals its destination.

Two requests can need the same output of one element, even when their final destinations differ. In that case the request on the element's upper input wins. The other request goes no further, and a blocked flag is raised for the source that sent it. Each delivered word carries the index of its source, so the receiver knows where it came from.

The network itself is combinational. With the default setting, a register stage sits on every output and on the blocked flags. The block suits fabrics that settle contention on their own and leave retry to the requester.

Top module: `omega_net`

## Requirements
- R1: A lone valid request from any source s to any destination d appears on output port d, with out_valid bit d set, its own data word, and source field s. No blocked flag is raised.
- R2: The lines are rewired before every stage by a perfect shuffle. The shuffle moves line i to line ((2*i) mod N) + (i div (N/2)). The element at stage k sends a request to its even (upper) output when destination bit (log2(N)-1-k) is 0, and to its odd (lower) output when that bit is 1.
- R3: When every source is valid and source i targets destination (i+s) mod N for one shift s, all N requests are delivered and no blocked flag is raised.
- R4: When both inputs of an element need the same output, the request entering on the even-numbered line passes. The other request is dropped, and bit b of req_blocked is set, where b is its source index.
- R5: When two sources name the same destination, at most one of them is delivered on that port. The other one's blocked flag is set.
- R6: Every valid request is either delivered or blocked, never both. An invalid source is never flagged as blocked.
- R7: With OUT_REG=1, out_valid, out_src, out_data and req_blocked show the result for the inputs present at the previous rising clock edge. While rst_n is low, out_valid and req_blocked read all zero.
- R8: The destination and data of a source whose valid bit is 0 have no effect on any output.
- R9: The network is blocking. For N=8, source 0 to destination 0 and source 4 to destination 1 meet in the first-stage element. Only source 0 is delivered, and source 4 is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per source |
| req_dest | input | N_PORTS*log2(N_PORTS) | Destination port number per source; source i uses slice i |
| req_data | input | N_PORTS*DATA_W | Data word per source; source i uses slice i |
| out_valid | output | N_PORTS | A word is delivered on this output port |
| out_src | output | N_PORTS*log2(N_PORTS) | Source index of the word on each output port |
| out_data | output | N_PORTS*DATA_W | Data word on each output port |
| req_blocked | output | N_PORTS | Request of this source was lost to contention |

## Verification
The bench sweeps every single source-to-destination pair. A wrong shuffle or a wrong choice of routing bit would send words to the wrong port, or raise blocked flags where none should appear.

All cyclic shifts are applied. A design that flags contention too eagerly would block requests that must route freely.

Hand-built collisions check that the upper input wins. This covers two requests meeting on an internal link with different destinations, and two requests naming the same destination. A reversed priority would deliver the wrong source's word.

Several hundred pseudo-random request sets are compared against an arithmetic model of the stages. These sets include invalid sources carrying junk. A design that let idle inputs take part in arbitration, or that lost or duplicated a request, would break delivery or the conservation check.

// File: rtl/omega_pkg.sv
// Shared helpers for the multistage switching network.
// Assumes line counts are powers of two and lg is at least 1.
package omega_pkg;

    // Perfect shuffle: one-bit left rotation of an lg-bit line index.
    function automatic int unsigned shuffle_idx(input int unsigned idx,
                                                input int unsigned lg);
        int unsigned mask;
        mask = (32'd1 << lg) - 32'd1;
        return ((idx << 1) | (idx >> (lg - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch2.sv
// One 2x2 routing element.
// Each packet is {valid, dest, src, data}.
// The routing bit of the destination picks the output port: 0 selects the upper port, 1 selects the lower.
// The upper input always has priority. A lower-input packet that needs a taken port is dropped and reported.
module omega_switch2 #(
    parameter int LG     = 3,
    parameter int DW     = 8,
    parameter int BITSEL = 2
) (
    input  logic [DW+2*LG:0] in_u,
    input  logic [DW+2*LG:0] in_l,
    output logic [DW+2*LG:0] out_u,
    output logic [DW+2*LG:0] out_l,
    output logic             lost,
    output logic [LG-1:0]    lost_src
);
    localparam int PW    = DW + 2*LG + 1;
    localparam int V_POS = PW - 1;
    localparam int R_POS = DW + LG + BITSEL;

    logic u_v, l_v, u_b, l_b;
    logic u_to_up, u_to_dn, l_to_up, l_to_dn;

    // Decide port use with the upper input first, then steer the packets.
    always_comb begin
        u_v     = in_u[V_POS];
        l_v     = in_l[V_POS];
        u_b     = in_u[R_POS];
        l_b     = in_l[R_POS];
        u_to_up = u_v & ~u_b;
        u_to_dn = u_v & u_b;
        l_to_up = l_v & ~l_b & ~u_to_up;
        l_to_dn = l_v & l_b & ~u_to_dn;
        out_u   = u_to_up ? in_u : (l_to_up ? in_l : '0);
        out_l   = u_to_dn ? in_u : (l_to_dn ? in_l : '0);
        lost    = l_v & ~l_to_up & ~l_to_dn;
        lost_src = in_l[DW +: LG];
    end
endmodule

// File: rtl/omega_stage.sv
// One stage of the network.
// A perfect shuffle is applied to the incoming lines, and the result feeds N/2 routing elements.
// The stage also returns a per-source mask of the requests it dropped.
// Assumes N is a power of two, at least 2.
module omega_stage #(
    parameter int N     = 8,
    parameter int LG    = 3,
    parameter int DW    = 8,
    parameter int STAGE = 0
) (
    input  logic [N*(DW+2*LG+1)-1:0] in_bus,
    output logic [N*(DW+2*LG+1)-1:0] out_bus,
    output logic [N-1:0]             drop_mask
);
    localparam int PW   = DW + 2*LG + 1;
    localparam int HALF = N / 2;
    localparam int RBIT = LG - 1 - STAGE;

    logic [N*PW-1:0]   shuf;
    logic [HALF-1:0]   sw_lost;
    logic [HALF*LG-1:0] sw_lost_src;

    for (genvar i = 0; i < N; i++) begin : g_shuf
        assign shuf[omega_pkg::shuffle_idx(i, LG)*PW +: PW] = in_bus[i*PW +: PW];
    end

    for (genvar j = 0; j < HALF; j++) begin : g_sw
        omega_switch2 #(.LG(LG), .DW(DW), .BITSEL(RBIT)) sw_i (
            .in_u    (shuf[(2*j)*PW +: PW]),
            .in_l    (shuf[(2*j+1)*PW +: PW]),
            .out_u   (out_bus[(2*j)*PW +: PW]),
            .out_l   (out_bus[(2*j+1)*PW +: PW]),
            .lost    (sw_lost[j]),
            .lost_src(sw_lost_src[j*LG +: LG])
        );
    end

    // Turn the per-element drop reports into a mask indexed by source.
    always_comb begin
        drop_mask = '0;
        for (int j = 0; j < HALF; j++) begin
            if (sw_lost[j]) drop_mask[sw_lost_src[j*LG +: LG]] = 1'b1;
        end
    end
endmodule

// File: rtl/omega_net.sv
// Top of the multistage switching network.
// It has log2(N) shuffle-connected stages of 2x2 elements, steered by destination bits.
// Each source's index is attached to its word.
// Requests lost to contention are flagged per source.
// OUT_REG=1 adds one register stage on all outputs, cleared by synchronous active-low reset.
// Assumes N_PORTS is a power of two, at least 2.
module omega_net #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    parameter int OUT_REG = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_PORTS-1:0]                  req_valid,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0]  req_dest,
    input  logic [N_PORTS*DATA_W-1:0]           req_data,
    output logic [N_PORTS-1:0]                  out_valid,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0]  out_src,
    output logic [N_PORTS*DATA_W-1:0]           out_data,
    output logic [N_PORTS-1:0]                  req_blocked
);
    localparam int LG = $clog2(N_PORTS);
    localparam int PW = DATA_W + 2*LG + 1;

    logic [N_PORTS*PW-1:0]     bus [LG+1];
    logic [N_PORTS-1:0]        drop [LG];
    logic [N_PORTS-1:0]        dlv_v;
    logic [N_PORTS*LG-1:0]     dlv_src;
    logic [N_PORTS*LG-1:0]     dlv_dest;
    logic [N_PORTS*DATA_W-1:0] dlv_data;
    logic [N_PORTS-1:0]        blk_all;

    // Build the entry packets. Idle sources enter as empty packets.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_entry
        localparam logic [LG-1:0] SRC_ID = LG'(i);
        assign bus[0][i*PW +: PW] = req_valid[i]
            ? {1'b1, req_dest[i*LG +: LG], SRC_ID, req_data[i*DATA_W +: DATA_W]}
            : '0;
    end

    for (genvar k = 0; k < LG; k++) begin : g_stage
        omega_stage #(.N(N_PORTS), .LG(LG), .DW(DATA_W), .STAGE(k)) stage_i (
            .in_bus   (bus[k]),
            .out_bus  (bus[k+1]),
            .drop_mask(drop[k])
        );
    end

    // Take the last stage's lines apart into per-port fields.
    for (genvar o = 0; o < N_PORTS; o++) begin : g_exit
        assign dlv_v[o]                      = bus[LG][o*PW + PW - 1];
        assign dlv_dest[o*LG +: LG]          = bus[LG][o*PW + DATA_W + LG +: LG];
        assign dlv_src[o*LG +: LG]           = bus[LG][o*PW + DATA_W +: LG];
        assign dlv_data[o*DATA_W +: DATA_W]  = bus[LG][o*PW +: DATA_W];
    end

    // Merge the drop masks of all stages.
    always_comb begin
        blk_all = '0;
        for (int k = 0; k < LG; k++) blk_all = blk_all | drop[k];
    end

    if (OUT_REG != 0) begin : g_reg
        // Register every output; reset clears the flags and the fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid   <= '0;
                out_src     <= '0;
                out_data    <= '0;
                req_blocked <= '0;
            end else begin
                out_valid   <= dlv_v;
                out_src     <= dlv_src;
                out_data    <= dlv_data;
                req_blocked <= blk_all;
            end
        end

        a_r7_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(dlv_v) && req_blocked == $past(blk_all)));
    end else begin : g_comb
        assign out_valid   = dlv_v;
        assign out_src     = dlv_src;
        assign out_data    = dlv_data;
        assign req_blocked = blk_all;
    end

    a_r6_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dlv_v) + $countones(blk_all)) == $countones(req_valid));

    a_r6_idle_not_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_all & ~req_valid) == '0);

    for (genvar o = 0; o < N_PORTS; o++) begin : g_chk
        a_r1_port_matches_dest: assert property (@(posedge clk) disable iff (!rst_n)
            dlv_v[o] |-> (dlv_dest[o*LG +: LG] == LG'(o)));
        a_r6_src_was_valid: assert property (@(posedge clk) disable iff (!rst_n)
            dlv_v[o] |-> req_valid[dlv_src[o*LG +: LG]]);
    end
endmodule

// File: tb/omega_net_tb.sv
module omega_net_tb_top;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int LG    = 3;
    localparam int DW    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N*LG-1:0]   req_dest = '0;
    logic [N*DW-1:0]   req_data = '0;
    logic [N-1:0]      out_valid;
    logic [N*LG-1:0]   out_src;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      req_blocked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int t_dst [N];
    int t_dat [N];
    logic [N-1:0] t_v;
    logic [N-1:0] e_v, e_blk;
    int e_src [N];
    int e_dat [N];
    logic [31:0] lfsr = 32'h1234_5679;

    omega_net #(.N_PORTS(N), .DATA_W(DW), .OUT_REG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_data(req_data), .out_valid(out_valid), .out_src(out_src),
        .out_data(out_data), .req_blocked(req_blocked)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: all requirements, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = t_v[i];
            req_dest[i*LG +: LG]   = LG'(t_dst[i]);
            req_data[i*DW +: DW]   = DW'(t_dat[i]);
        end
    endtask

    // Arithmetic stage model: shuffle i -> (2i mod N) + i/(N/2); upper input claims first.
    task automatic model();
        int occ [N];
        int tmp [N];
        int nxt [N];
        e_blk = '0;
        for (int i = 0; i < N; i++) occ[i] = t_v[i] ? i : -1;
        for (int k = 0; k < LG; k++) begin
            for (int i = 0; i < N; i++) tmp[(2*i) % N + i / (N/2)] = occ[i];
            for (int i = 0; i < N; i++) nxt[i] = -1;
            for (int j = 0; j < N/2; j++) begin
                int u = tmp[2*j];
                int l = tmp[2*j+1];
                if (u >= 0) nxt[2*j + ((t_dst[u] >> (LG-1-k)) & 1)] = u;
                if (l >= 0) begin
                    int t = 2*j + ((t_dst[l] >> (LG-1-k)) & 1);
                    if (nxt[t] >= 0) e_blk[l] = 1'b1;
                    else nxt[t] = l;
                end
            end
            for (int i = 0; i < N; i++) occ[i] = nxt[i];
        end
        for (int o = 0; o < N; o++) begin
            e_v[o]   = (occ[o] >= 0);
            e_src[o] = (occ[o] >= 0) ? occ[o] : 0;
            e_dat[o] = (occ[o] >= 0) ? t_dat[occ[o]] : 0;
        end
    endtask

    task automatic compare(input string req);
        chk(req, "out_valid", 64'(out_valid), 64'(e_v));
        chk(req, "req_blocked", 64'(req_blocked), 64'(e_blk));
        chk(req, "conservation", 64'($countones(out_valid) + $countones(req_blocked)),
            64'($countones(t_v)));
        for (int o = 0; o < N; o++) begin
            if (e_v[o]) begin
                chk(req, "out_src", 64'(out_src[o*LG +: LG]), 64'(e_src[o]));
                chk(req, "out_data", 64'(out_data[o*DW +: DW]), 64'(e_dat[o]));
            end
        end
    endtask

    task automatic run(input string req);
        @(negedge clk);
        drive();
        model();
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic clear_req();
        t_v = '0;
        for (int i = 0; i < N; i++) begin
            t_dst[i] = 0;
            t_dat[i] = 0;
        end
    endtask

    initial begin
        // R7: reset holds outputs at zero even with requests present
        clear_req();
        for (int i = 0; i < N; i++) begin
            t_v[i] = 1'b1;
            t_dst[i] = (i + 3) % N;
            t_dat[i] = 8'hA0 + i;
        end
        @(negedge clk);
        drive();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7", "reset out_valid", 64'(out_valid), 64'd0);
        chk("R7", "reset req_blocked", 64'(req_blocked), 64'd0);
        rst_n = 1'b1;

        // R7: latency of one clock
        clear_req();
        run("R7");
        clear_req();
        t_v[5] = 1'b1;
        t_dst[5] = 2;
        t_dat[5] = 8'h5C;
        @(negedge clk);
        drive();
        model();
        #1;
        chk("R7", "before edge out_valid", 64'(out_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        compare("R7");

        // R1: every single source/destination pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                clear_req();
                t_v[s] = 1'b1;
                t_dst[s] = d;
                t_dat[s] = (s * 16 + d * 3 + 1) & 8'hFF;
                run("R1");
                chk("R1", "single port", 64'(out_valid), 64'(1) << d);
                chk("R1", "single not blocked", 64'(req_blocked), 64'd0);
            end
        end

        // R3: every cyclic shift routes without blocking
        for (int s = 0; s < N; s++) begin
            clear_req();
            for (int i = 0; i < N; i++) begin
                t_v[i] = 1'b1;
                t_dst[i] = (i + s) % N;
                t_dat[i] = (i * 37 + s) & 8'hFF;
            end
            run("R3");
            chk("R3", "shift all delivered", 64'(out_valid), 64'hFF);
            chk("R3", "shift none blocked", 64'(req_blocked), 64'd0);
        end

        // R9 and R4: distinct destinations collide in the first stage; upper wins
        clear_req();
        t_v[0] = 1'b1; t_dst[0] = 0; t_dat[0] = 8'h11;
        t_v[4] = 1'b1; t_dst[4] = 1; t_dat[4] = 8'h44;
        run("R9");
        chk("R9", "internal collision valid", 64'(out_valid), 64'h01);
        chk("R4", "lower input flagged", 64'(req_blocked), 64'h10);
        chk("R4", "winner src", 64'(out_src[0 +: LG]), 64'd0);

        // R5: same destination; source 1 enters on the upper input
        clear_req();
        t_v[1] = 1'b1; t_dst[1] = 3; t_dat[1] = 8'h21;
        t_v[5] = 1'b1; t_dst[5] = 3; t_dat[5] = 8'h25;
        run("R5");
        chk("R5", "one delivered", 64'(out_valid), 64'h08);
        chk("R5", "winner src", 64'(out_src[3*LG +: LG]), 64'd1);
        chk("R5", "loser flagged", 64'(req_blocked), 64'h20);

        // R8: idle sources carrying a colliding destination and junk data have no effect
        clear_req();
        for (int i = 0; i < N; i++) begin
            t_dst[i] = 6;
            t_dat[i] = 8'hEE;
        end
        t_v[2] = 1'b1; t_dat[2] = 8'h3D;
        run("R8");
        chk("R8", "only one port", 64'(out_valid), 64'h40);
        chk("R8", "no flags", 64'(req_blocked), 64'd0);
        chk("R8", "data kept", 64'(out_data[6*DW +: DW]), 64'h3D);

        // R2 and R6: pseudo-random request sets against the stage model
        for (int r = 0; r < 400; r++) begin
            for (int i = 0; i < N; i++) begin
                lfsr = next_rand(lfsr);
                t_v[i] = lfsr[3] | lfsr[7];
                t_dst[i] = int'(lfsr[12:10]);
                t_dat[i] = int'(lfsr[27:20]);
            end
            run("R2_R6");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule